// File: doc/BRIEF.md
# Single-Bit AND Execution Unit

This unit carries out one instruction of an 8-bit controller: a logical AND of two single bits, one of them picked by index from a register and the other taken from bit 0 of a second register. The result goes into one bit of whichever operand is the destination. The unit holds its own model of the register storage: a 16-byte working bank and a 256-byte general bank, kept apart. It also holds the flag byte. Test ports let a bench preload and inspect both banks and the flags.

A one-cycle start strobe presents all three instruction bytes together. The opcode byte must be 0x67. The second byte packs the working-register number, the bit index and a direction bit. The third byte is a full general-register address. Execution takes a fixed six cycles. During that time busy stays high and any new strobe is dropped. When execution ends, the unit writes the destination bit, updates the zero and sign flags, and pulses done. Any other opcode byte raises a one-cycle illegal pulse and leaves every register and flag as it was.

Top module: `bitand_unit`

## Requirements
- R1: The unit accepts a strobe only when op_byte equals 0x67. In sel_byte, bits 7..4 name the working register, bits 3..1 give the bit index b, and bit 0 is the direction bit.
- R2: With direction 0, bit 0 of the working register becomes its old bit 0 AND bit b of the general register at addr_byte.
- R3: With direction 1, bit b of the general register at addr_byte becomes its old bit b AND bit 0 of the working register.
- R4: Only the target bit of the destination changes. Its other bits and the whole source register stay as they were.
- R5: When execution ends, Z (flags bit 6) is set if the result bit is 0 and cleared if it is 1. S (flags bit 5) is cleared.
- R6: C (bit 7), V (bit 4), D (bit 3), H (bit 2) and bits 1..0 of the flags stay unchanged.
- R7: busy is high for exactly six cycles, beginning the cycle after the accepting edge. The register write, the flag update and a one-cycle done pulse all take effect on the edge where busy falls.
- R8: A strobe that arrives while busy is high has no effect on the running instruction, the registers or the flags.
- R9: A strobe with any opcode other than 0x67 while idle gives illegal high for the next cycle only. It does not set busy and changes no register or flag.
- R10: After reset, busy, done, illegal and flags are all 0. A test write stores a byte in the bank chosen by tw_gen (1 = general, 0 = working; the working bank uses address bits 3..0). tr_rdata returns the addressed byte combinationally. flag_load replaces the flags.
- R11: With working register 1 at 0x07, general register 0x01 at 0x05, index 1 and direction 0, working register 1 becomes 0x06 and general register 0x01 stays 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle instruction strobe |
| op_byte | input | 8 | Opcode byte |
| sel_byte | input | 8 | Packed working register, bit index, direction |
| addr_byte | input | 8 | General register address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unknown-opcode pulse |
| flags | output | 8 | Flag register |
| flag_load | input | 1 | Load flags from flag_wdata |
| flag_wdata | input | 8 | Flag preload value |
| tw_we | input | 1 | Test write enable |
| tw_gen | input | 1 | Test write bank select (1 general) |
| tw_addr | input | 8 | Test write address |
| tw_wdata | input | 8 | Test write data |
| tr_gen | input | 1 | Test read bank select (1 general) |
| tr_addr | input | 8 | Test read address |
| tr_rdata | output | 8 | Test read data |

## Verification
The assertions assume that flag_load and test writes are used only while the unit is idle. They also assume the register banks keep their values for the six cycles of an instruction, because the result is formed from the banks as they stand on the final edge. The bench respects both assumptions: it does all preloads and flag loads before it issues a strobe, and it waits until done before it touches either port again. The only traffic it sends during busy is the extra strobes it injects on purpose to test that they are dropped.

// File: rtl/bitand_pkg.sv
package bitand_pkg;
    localparam int unsigned DW       = 8;
    localparam logic [7:0]  OPC_BAND = 8'h67;
    localparam int unsigned FLG_C    = 7;
    localparam int unsigned FLG_Z    = 6;
    localparam int unsigned FLG_S    = 5;
    localparam int unsigned FLG_V    = 4;
    localparam int unsigned FLG_D    = 3;
    localparam int unsigned FLG_H    = 2;

    // Packed operand byte: working register, bit index, direction.
    typedef struct packed {
        logic [3:0] wsel;
        logic [2:0] bidx;
        logic       dir;
    } opsel_t;
endpackage

// File: rtl/bitand_rf.sv
// Register storage model: a working bank and a general bank, kept apart.
// Assumes the execution write and a test write never target the same
// cycle; if they do, the execution write wins. Storage is not reset.
module bitand_rf #(
    parameter int unsigned WDEPTH = 16,
    parameter int unsigned GDEPTH = 256,
    parameter int unsigned DW     = 8
) (
    input  logic                      clk,
    input  logic                      ex_we,
    input  logic                      ex_gen,
    input  logic [$clog2(GDEPTH)-1:0] ex_addr,
    input  logic [DW-1:0]             ex_wdata,
    input  logic                      t_we,
    input  logic                      t_gen,
    input  logic [$clog2(GDEPTH)-1:0] t_waddr,
    input  logic [DW-1:0]             t_wdata,
    input  logic [$clog2(WDEPTH)-1:0] w_idx,
    output logic [DW-1:0]             w_rdata,
    input  logic [$clog2(GDEPTH)-1:0] g_idx,
    output logic [DW-1:0]             g_rdata,
    input  logic                      t_rgen,
    input  logic [$clog2(GDEPTH)-1:0] t_raddr,
    output logic [DW-1:0]             t_rdata
);
    localparam int unsigned WAW = $clog2(WDEPTH);

    logic [DW-1:0] wbank [WDEPTH];
    logic [DW-1:0] gbank [GDEPTH];

    // Write port: execution result first, test preload otherwise.
    always_ff @(posedge clk) begin
        if (ex_we) begin
            if (ex_gen) gbank[ex_addr] <= ex_wdata;
            else        wbank[ex_addr[WAW-1:0]] <= ex_wdata;
        end else if (t_we) begin
            if (t_gen) gbank[t_waddr] <= t_wdata;
            else       wbank[t_waddr[WAW-1:0]] <= t_wdata;
        end
    end

    // Combinational read ports for operands and for test inspection.
    always_comb begin
        w_rdata = wbank[w_idx];
        g_rdata = gbank[g_idx];
        t_rdata = t_rgen ? gbank[t_raddr] : wbank[t_raddr[WAW-1:0]];
    end
endmodule

// File: rtl/bitand_alu.sv
// Bit operation: selects destination and source by direction, ANDs the
// indexed bit with bit 0 of the other operand, rebuilds the destination.
// Assumes purely combinational use; no state.
module bitand_alu #(
    parameter int unsigned DW = 8
) (
    input  logic                  dir,
    input  logic [$clog2(DW)-1:0] bidx,
    input  logic [DW-1:0]         wval,
    input  logic [DW-1:0]         gval,
    output logic [DW-1:0]         dst_old,
    output logic [DW-1:0]         dst_new,
    output logic                  res
);
    // Pick operands, form the result bit and insert it.
    always_comb begin
        dst_new = dir ? gval : wval;
        dst_old = dst_new;
        if (dir) begin
            res           = gval[bidx] & wval[0];
            dst_new[bidx] = res;
        end else begin
            res        = wval[0] & gval[bidx];
            dst_new[0] = res;
        end
    end
endmodule

// File: rtl/bitand_seq.sv
// Sequencer: accepts a legal strobe while idle, stays busy for CYC
// cycles, fires the write-back on the last edge, pulses done after it.
// Assumes start is a single-cycle strobe; strobes while busy are dropped.
module bitand_seq #(
    parameter int unsigned CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal,
    output logic accept,
    output logic fire,
    output logic busy,
    output logic done,
    output logic illegal
);
    localparam int unsigned CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    // Accept and completion decode.
    always_comb begin
        accept = start && !busy && legal;
        fire   = busy && (cnt == CW'(CYC - 1));
    end

    // Busy window, cycle count and the one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= fire;
            illegal <= start && !busy && !legal;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (fire) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_done_follows_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    assert_busy_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fire) |=> busy);
    assert_illegal_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !done));
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < CW'(CYC)));
endmodule

// File: rtl/bitand_unit.sv
// Single-bit AND execution unit. Latches the instruction on an accepted
// strobe, runs the sequencer, then writes one destination bit and the
// zero/sign flags. Assumes flag_load and test writes occur only while idle.
module bitand_unit #(
    parameter int unsigned WDEPTH = 16,
    parameter int unsigned GDEPTH = 256,
    parameter int unsigned CYC    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] op_byte,
    input  logic [7:0] sel_byte,
    input  logic [7:0] addr_byte,
    output logic       busy,
    output logic       done,
    output logic       illegal,
    output logic [7:0] flags,
    input  logic       flag_load,
    input  logic [7:0] flag_wdata,
    input  logic       tw_we,
    input  logic       tw_gen,
    input  logic [7:0] tw_addr,
    input  logic [7:0] tw_wdata,
    input  logic       tr_gen,
    input  logic [7:0] tr_addr,
    output logic [7:0] tr_rdata
);
    import bitand_pkg::*;

    localparam int unsigned GAW = $clog2(GDEPTH);
    localparam int unsigned WAW = $clog2(WDEPTH);
    localparam int unsigned BW  = $clog2(DW);

    opsel_t        ins_sel;
    logic [7:0]    ins_addr;
    logic          legal, accept, fire, res;
    logic [DW-1:0] wval, gval, dst_old, dst_new;
    logic [GAW-1:0] ex_addr;

    // Opcode decode for the single supported instruction.
    always_comb legal = (op_byte == OPC_BAND);

    // Instruction latch, loaded on an accepted strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_sel  <= '0;
            ins_addr <= '0;
        end else if (accept) begin
            ins_sel  <= opsel_t'(sel_byte);
            ins_addr <= addr_byte;
        end
    end

    bitand_seq #(.CYC(CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .legal(legal),
        .accept(accept), .fire(fire), .busy(busy), .done(done),
        .illegal(illegal)
    );

    // Destination address: general register or zero-extended working index.
    always_comb ex_addr = ins_sel.dir ? GAW'(ins_addr) : GAW'(ins_sel.wsel);

    bitand_rf #(.WDEPTH(WDEPTH), .GDEPTH(GDEPTH), .DW(DW)) u_rf (
        .clk(clk),
        .ex_we(fire), .ex_gen(ins_sel.dir), .ex_addr(ex_addr), .ex_wdata(dst_new),
        .t_we(tw_we), .t_gen(tw_gen), .t_waddr(GAW'(tw_addr)), .t_wdata(tw_wdata),
        .w_idx(WAW'(ins_sel.wsel)), .w_rdata(wval),
        .g_idx(GAW'(ins_addr)), .g_rdata(gval),
        .t_rgen(tr_gen), .t_raddr(GAW'(tr_addr)), .t_rdata(tr_rdata)
    );

    bitand_alu #(.DW(DW)) u_alu (
        .dir(ins_sel.dir), .bidx(BW'(ins_sel.bidx)), .wval(wval), .gval(gval),
        .dst_old(dst_old), .dst_new(dst_new), .res(res)
    );

    // Flag register: execution update, else test preload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (fire) begin
            flags[FLG_Z] <= ~res;
            flags[FLG_S] <= 1'b0;
        end else if (flag_load) begin
            flags <= flag_wdata;
        end
    end

    assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($countones(dst_new ^ dst_old) <= 1));
    assert_sign_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flags[FLG_S]);
    assert_keep_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(flag_load)) |->
        ({flags[FLG_C], flags[FLG_V], flags[FLG_D], flags[FLG_H], flags[1:0]} ==
         $past({flags[FLG_C], flags[FLG_V], flags[FLG_D], flags[FLG_H], flags[1:0]})));
    assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable(flags));
endmodule

// File: tb/sim_bitand_unit.sv
module sim_bitand_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] op_byte = '0, sel_byte = '0, addr_byte = '0;
    logic busy, done, illegal;
    logic [7:0] flags;
    logic flag_load = 1'b0;
    logic [7:0] flag_wdata = '0;
    logic tw_we = 1'b0, tw_gen = 1'b0;
    logic [7:0] tw_addr = '0, tw_wdata = '0;
    logic tr_gen = 1'b0;
    logic [7:0] tr_addr = '0;
    logic [7:0] tr_rdata;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    bitand_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_byte(op_byte),
        .sel_byte(sel_byte), .addr_byte(addr_byte), .busy(busy), .done(done),
        .illegal(illegal), .flags(flags), .flag_load(flag_load),
        .flag_wdata(flag_wdata), .tw_we(tw_we), .tw_gen(tw_gen),
        .tw_addr(tw_addr), .tw_wdata(tw_wdata), .tr_gen(tr_gen),
        .tr_addr(tr_addr), .tr_rdata(tr_rdata)
    );

    // Behavioural reference state.
    logic [7:0] m_w [16];
    logic [7:0] m_g [256];
    logic [7:0] m_flags;
    bit   m_busy, m_done, m_ill;
    int   m_cnt;
    logic [7:0] m_sel, m_addr;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_ill = 0; m_cnt = 0; m_flags = 8'h00;
        end else begin
            m_done = 0;
            m_ill  = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 6) begin
                    int w, b;
                    bit r;
                    w = m_sel >> 4;
                    b = (m_sel >> 1) & 7;
                    if (m_sel[0] == 1'b0) begin
                        r = m_w[w][0] & m_g[m_addr][b];
                        m_w[w][0] = r;
                    end else begin
                        r = m_g[m_addr][b] & m_w[w][0];
                        m_g[m_addr][b] = r;
                    end
                    m_flags[6] = !r;
                    m_flags[5] = 1'b0;
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start) begin
                if (op_byte == 8'h67) begin
                    m_busy = 1; m_cnt = 0; m_sel = sel_byte; m_addr = addr_byte;
                end else begin
                    m_ill = 1;
                end
            end
            if (flag_load && !(m_done)) m_flags = flag_wdata;
            if (tw_we) begin
                if (tw_gen) m_g[tw_addr] = tw_wdata;
                else        m_w[tw_addr[3:0]] = tw_wdata;
            end
        end
    end

    // Per-cycle comparison of outputs, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R7 busy", busy, m_busy);
            check(done == m_done, "R7 done", done, m_done);
            check(illegal == m_ill, "R9 illegal", illegal, m_ill);
            check(flags == m_flags, "R5/R6 flags", flags, m_flags);
        end
    end

    task automatic twrite(input bit gen, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        tw_we = 1; tw_gen = gen; tw_addr = a; tw_wdata = d;
        @(negedge clk);
        tw_we = 0;
    endtask

    task automatic fload(input logic [7:0] v);
        @(negedge clk);
        flag_load = 1; flag_wdata = v;
        @(negedge clk);
        flag_load = 0;
    endtask

    task automatic readback(input bit gen, input logic [7:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        tr_gen = gen; tr_addr = a;
        #1;
        e = gen ? m_g[a] : m_w[a[3:0]];
        check(tr_rdata == e, tag, tr_rdata, e);
    endtask

    // Issue one strobe; optionally inject a second strobe while busy.
    task automatic run_op(input logic [7:0] op, input logic [7:0] sel,
                          input logic [7:0] ad, input bit inject);
        @(negedge clk);
        start = 1; op_byte = op; sel_byte = sel; addr_byte = ad;
        @(negedge clk);
        start = 0;
        if (inject) begin
            @(negedge clk);
            start = 1; op_byte = 8'h67; sel_byte = ~sel; addr_byte = ~ad;
            @(negedge clk);
            start = 0;
            @(negedge clk);
            start = 1; op_byte = 8'h12;
            @(negedge clk);
            start = 0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic op_and_check(input logic [7:0] sel, input logic [7:0] ad, input bit inject);
        run_op(8'h67, sel, ad, inject);
        if (sel[0]) begin
            readback(1, ad, "R3 dest general");
            readback(0, {4'h0, sel[7:4]}, "R4 source working");
        end else begin
            readback(0, {4'h0, sel[7:4]}, "R2 dest working");
            readback(1, ad, "R4 source general");
        end
    endtask

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && illegal == 0 && flags == 0,
              "R10 reset state", {busy, done, illegal, flags}, 0);
        rst_n = 1;

        for (int i = 0; i < 16; i++) twrite(0, 8'(i), 8'(8'h3B * i + 1));
        for (int i = 0; i < 256; i++) twrite(1, 8'(i), 8'(i) ^ 8'hA6);
        readback(1, 8'h80, "R10 test port general");
        readback(0, 8'h0E, "R10 test port working");

        // R11 check case
        twrite(0, 8'h01, 8'h07);
        twrite(1, 8'h01, 8'h05);
        run_op(8'h67, {4'd1, 3'd1, 1'b0}, 8'h01, 0);
        readback(0, 8'h01, "R11 working reg becomes 06");
        check(m_w[1] == 8'h06, "R11 model", m_w[1], 8'h06);
        readback(1, 8'h01, "R11 source stays 05");

        // R5 R6 flags preloaded with all ones, result 1 clears Z
        fload(8'hFF);
        twrite(0, 8'h0F, 8'hFF);
        twrite(1, 8'hFF, 8'h80);
        op_and_check({4'd15, 3'd7, 1'b1}, 8'hFF, 0);
        check(flags == 8'b1001_1111, "R5 R6 flags after result 1", flags, 8'h9F);

        // R3 dir 1 with working bit 0 cleared
        twrite(0, 8'h03, 8'hFE);
        twrite(1, 8'h40, 8'hFF);
        op_and_check({4'd3, 3'd4, 1'b1}, 8'h40, 0);
        readback(1, 8'h40, "R3 bit4 cleared to EF");

        // R8 strobes during busy ignored
        op_and_check({4'd5, 3'd2, 1'b0}, 8'h22, 1);
        op_and_check({4'd9, 3'd6, 1'b1}, 8'h9C, 1);

        // R9 / R1 illegal opcodes
        fload(8'h00);
        run_op(8'h66, {4'd1, 3'd0, 1'b0}, 8'h01, 0);
        readback(0, 8'h01, "R9 illegal no change");
        run_op(8'hE7, {4'd2, 3'd3, 1'b1}, 8'h02, 0);
        readback(1, 8'h02, "R9 illegal no change general");

        // Varied patterns, R1 field decoding
        seed = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            logic [7:0] s, a;
            seed = seed * 32'd1103515245 + 32'd12345;
            s = seed[23:16];
            a = seed[15:8];
            if (k % 5 == 0) fload(seed[31:24]);
            op_and_check(s, a, k % 7 == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule